// File: doc/BRIEF.md
# Addressable-Frame Serial Transmitter

This block is an asynchronous serial transmitter for a bus of several receivers that tell address frames from data frames. Every frame carries one extra bit after the data byte. Software picks its value frame by frame: 1 marks an address frame and 0 marks a data frame. A holding register sits in front of a shift register. Two flags track progress: a holding-empty flag says the next byte may be written, and a done flag says the line has gone quiet. An interrupt request follows the holding-empty flag. A DMA-style writer can answer that request through a side port, and that write also releases the byte with no further action.

A small register bus reaches four registers. Software writes a byte, then writes the status register with the empty bit at 0 and the chosen address/data bit; this hands the byte to the shifter. Bit timing comes from an external tick enable, and each bit lasts a fixed number of ticks. While the transmitter is disabled, the pin falls back to a general-purpose port level and direction pair. This gives software a way to hold the line low as a break after the last frame.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset the transmitter is disabled, `txd` is high, and the status register (address 1) reads empty bit 7 = 1, done bit 2 = 1 and address/data bit 0 = 0.
- R2: A frame on `txd` is a 0 start bit, then 8 data bits LSB first, then the address/data bit, then a 1 stop bit. Each bit lasts 16 cycles in which `baud_tick` is 1. While enabled with no frame in progress, the line stays high.
- R3: When the transmitter is enabled, the shifter is idle and the empty flag is 0, the next clock edge does four things: it captures the holding byte and the address/data bit, sets empty to 1, clears done to 0, and drives the start bit onto `txd`.
- R4: `txe_irq` is 1 exactly when the transmitter is enabled and the empty flag is 1.
- R5: A `dma_wr` pulse while empty is 1 writes `dma_wdata` into the holding register (address 0) and clears empty at the same edge, so the byte is then sent with no status write.
- R6: Done is set at the end of a stop bit only if empty is 1 and is not being cleared at that same edge. Otherwise done stays 0 and the next frame follows.
- R7: Writing 0 to the control register (address 2, bit 0 = enable) aborts any frame at the next edge and holds empty and done at 1 while disabled.
- R8: While disabled, `txd` follows port level bit 0 if port direction bit 1 of the port register (address 3) is 1, and is high otherwise. Level 0 with direction 1 produces a break.
- R9: A `dma_wr` pulse while empty is 0 has no effect: the holding register keeps its byte.
- R10: A status write with bit 7 = 1 leaves empty unchanged. Bit 0 is always written. Bit 2 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Bit-time tick enable, 16 per bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 holding, 1 status, 2 control, 3 port |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| dma_wr | input | 1 | DMA-style write into the holding register |
| dma_wdata | input | 8 | DMA write data |
| txd | output | 1 | Serial line |
| txe_irq | output | 1 | Holding-empty interrupt request |

## Verification
Two events can land on the same edge: the stop bit of one frame completes, and software clears the empty flag for the next byte. The bench waits until its model shows the last tick of the stop bit, then issues the clearing status write on exactly that edge. The check is that done never rises and the following start bit appears one cycle later. A reference model compares `txd`, `txe_irq` and the register being read on every cycle, so a wrongly ordered update shows up as a mismatch.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
   // register addresses
   localparam int REG_HOLD = 0;
   localparam int REG_STAT = 1;
   localparam int REG_CTRL = 2;
   localparam int REG_PORT = 3;
   // status bit positions
   localparam int ST_EMPTY = 7;
   localparam int ST_DONE  = 2;
   localparam int ST_ADDR  = 0;
   // start, data, address/data bit, stop
   function automatic int frame_len(input int data_w);
      return data_w + 3;
   endfunction
endpackage

// File: rtl/mp_uart_shift.sv
module mp_uart_shift #(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   input  logic              addr_bit,
   output logic              idle_o,
   output logic              done_o,
   output logic              line_o
);
   localparam int FRAME_W = mp_uart_pkg::frame_len(DATA_W);
   localparam int BIT_CW  = $clog2(FRAME_W);
   localparam int SUB_CW  = $clog2(OVERSAMPLE);

   if (OVERSAMPLE < 2) begin : g_bad_os
      $error("OVERSAMPLE must be at least 2");
   end

   logic [FRAME_W-1:0] shreg_q;
   logic [BIT_CW-1:0]  bit_q;
   logic [SUB_CW-1:0]  sub_q;
   logic               busy_q;
   logic               last_sub, last_bit;

   assign last_sub = (sub_q == SUB_CW'(OVERSAMPLE - 1));
   assign last_bit = (bit_q == BIT_CW'(FRAME_W - 1));
   assign done_o   = busy_q & tick & last_sub & last_bit;
   assign idle_o   = ~busy_q;
   assign line_o   = busy_q ? shreg_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '1;
         bit_q   <= '0;
         sub_q   <= '0;
         busy_q  <= 1'b0;
      end else if (!enable) begin
         shreg_q <= '1;
         bit_q   <= '0;
         sub_q   <= '0;
         busy_q  <= 1'b0;
      end else if (start) begin
         shreg_q <= {1'b1, addr_bit, data, 1'b0};
         bit_q   <= '0;
         sub_q   <= '0;
         busy_q  <= 1'b1;
      end else if (busy_q && tick) begin
         if (last_sub) begin
            sub_q <= '0;
            if (last_bit) begin
               busy_q <= 1'b0;
            end else begin
               bit_q   <= bit_q + BIT_CW'(1);
               shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
            end
         end else begin
            sub_q <= sub_q + SUB_CW'(1);
         end
      end
   end

   // R2
   start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && enable) |=> (line_o == 1'b0));
   // R2
   stop_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (idle_o && line_o));
endmodule

// File: rtl/mp_uart_regs.sv
module mp_uart_regs #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              dma_wr,
   input  logic [DATA_W-1:0] dma_wdata,
   input  logic              sh_idle,
   input  logic              sh_done,
   output logic              en_o,
   output logic              empty_o,
   output logic [DATA_W-1:0] hold_o,
   output logic              addr_bit_o,
   output logic              start_o,
   output logic              port_lvl_o,
   output logic              port_dir_o,
   output logic [DATA_W-1:0] rdata_o
);
   import mp_uart_pkg::*;

   if (DATA_W < 8) begin : g_bad_dw
      $error("DATA_W must be at least 8 to hold the status bits");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("ADDR_W must be at least 2");
   end

   logic              en_q, empty_q, done_q, abit_q, plvl_q, pdir_q;
   logic [DATA_W-1:0] hold_q;
   logic              wr_hold, wr_stat, wr_ctrl, wr_port, dma_take, clr_empty;

   assign wr_hold   = bus_wr && (bus_addr == ADDR_W'(REG_HOLD));
   assign wr_stat   = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
   assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
   assign wr_port   = bus_wr && (bus_addr == ADDR_W'(REG_PORT));
   assign dma_take  = dma_wr && empty_q;
   assign clr_empty = (wr_stat && !bus_wdata[ST_EMPTY]) || dma_take;
   assign start_o   = en_q && !empty_q && sh_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         done_q  <= 1'b1;
      end else if (!en_q) begin
         empty_q <= 1'b1;
         done_q  <= 1'b1;
      end else if (start_o) begin
         empty_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         if (clr_empty) empty_q <= 1'b0;
         if (sh_done && empty_q && !clr_empty) done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         abit_q <= 1'b0;
         en_q   <= 1'b0;
         plvl_q <= 1'b0;
         pdir_q <= 1'b0;
      end else begin
         if (dma_take)     hold_q <= dma_wdata;
         else if (wr_hold) hold_q <= bus_wdata;
         if (wr_stat) abit_q <= bus_wdata[ST_ADDR];
         if (wr_ctrl) en_q   <= bus_wdata[0];
         if (wr_port) begin
            plvl_q <= bus_wdata[0];
            pdir_q <= bus_wdata[1];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      case (bus_addr)
         ADDR_W'(REG_HOLD): rdata_o = hold_q;
         ADDR_W'(REG_STAT): begin
            rdata_o[ST_EMPTY] = empty_q;
            rdata_o[ST_DONE]  = done_q;
            rdata_o[ST_ADDR]  = abit_q;
         end
         ADDR_W'(REG_CTRL): rdata_o[0] = en_q;
         ADDR_W'(REG_PORT): rdata_o[1:0] = {pdir_q, plvl_q};
         default: rdata_o = '0;
      endcase
   end

   assign en_o       = en_q;
   assign empty_o    = empty_q;
   assign hold_o     = hold_q;
   assign addr_bit_o = abit_q;
   assign port_lvl_o = plvl_q;
   assign port_dir_o = pdir_q;

   // R3
   load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> (empty_q && !done_q));
   // R7
   disabled_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (empty_q && done_q));
   // R6
   done_rise_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> empty_q);
   // R9
   dma_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr && !empty_q && !wr_hold) |=> $stable(hold_q));
endmodule

// File: rtl/mp_uart_pin.sv
module mp_uart_pin #(
   parameter bit IDLE_HIGH = 1'b1
) (
   input  logic en,
   input  logic line,
   input  logic port_lvl,
   input  logic port_dir,
   output logic pin
);
   logic undriven;

   if (IDLE_HIGH) begin : g_pull_up
      assign undriven = 1'b1;
   end else begin : g_pull_down
      assign undriven = 1'b0;
   end

   assign pin = en ? line : (port_dir ? port_lvl : undriven);
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 2,
   parameter int OVERSAMPLE = 16,
   parameter bit IDLE_HIGH  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dma_wr,
   input  logic [DATA_W-1:0] dma_wdata,
   output logic              txd,
   output logic              txe_irq
);
   logic              en, empty, abit, start, idle, done, line, plvl, pdir;
   logic [DATA_W-1:0] hold;

   mp_uart_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
      .sh_idle(idle), .sh_done(done), .en_o(en), .empty_o(empty),
      .hold_o(hold), .addr_bit_o(abit), .start_o(start),
      .port_lvl_o(plvl), .port_dir_o(pdir), .rdata_o(bus_rdata)
   );

   mp_uart_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
      .clk(clk), .rst_n(rst_n), .enable(en), .tick(baud_tick),
      .start(start), .data(hold), .addr_bit(abit),
      .idle_o(idle), .done_o(done), .line_o(line)
   );

   mp_uart_pin #(.IDLE_HIGH(IDLE_HIGH)) u_pin (
      .en(en), .line(line), .port_lvl(plvl), .port_dir(pdir), .pin(txd)
   );

   assign txe_irq = en & empty;

   // R8
   break_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!bus_wr) && !en && pdir && !plvl) |-> !txd);
endmodule

// File: tb/mp_uart_tx_test.sv
module mp_uart_tx_test;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_T      = 16;
   localparam int LAST_T     = 11 * BIT_T - 1;

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0, dma_wr = 1'b0;
   logic [1:0] bus_addr = 2'd1;
   logic [7:0] bus_wdata = '0, dma_wdata = '0;
   wire  [7:0] bus_rdata;
   wire        txd, irq;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mp_uart_tx uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dma_wr(dma_wr), .dma_wdata(dma_wdata), .txd(txd), .txe_irq(irq)
   );

   int n_cmp = 0, n_bad = 0, tick_div = 1, cyc_n = 0;
   bit finished = 1'b0;
   string tx_tag = "R1", st_tag = "R1";

   // reference model
   bit m_en, m_empty, m_done, m_abit, m_busy, m_lvl, m_dir;
   int m_cnt;
   logic [7:0]  m_hold;
   logic [10:0] m_frame;

   task automatic model_reset();
      m_en = 0; m_empty = 1; m_done = 1; m_abit = 0; m_busy = 0;
      m_lvl = 0; m_dir = 0; m_cnt = 0; m_hold = '0; m_frame = '1;
   endtask

   task automatic model_edge();
      bit clr, fin;
      clr = (bus_wr && bus_addr == 2'd1 && !bus_wdata[7]) || (dma_wr && m_empty);
      if (!m_en) begin
         m_busy = 0; m_cnt = 0; m_empty = 1; m_done = 1;
      end else if (!m_busy && !m_empty) begin
         m_frame = {1'b1, m_abit, m_hold, 1'b0};
         m_busy = 1; m_cnt = 0; m_empty = 1; m_done = 0;
      end else begin
         fin = m_busy && tick && (m_cnt == LAST_T);
         if (m_busy && tick) begin
            if (fin) m_busy = 0;
            else m_cnt++;
         end
         if (fin && m_empty && !clr) m_done = 1;
         if (clr) m_empty = 0;
      end
      if (dma_wr && m_empty_prev_ok(clr)) m_hold = dma_wdata;
      else if (bus_wr && bus_addr == 2'd0) m_hold = bus_wdata;
      if (bus_wr && bus_addr == 2'd1) m_abit = bus_wdata[0];
      if (bus_wr && bus_addr == 2'd2) m_en = bus_wdata[0];
      if (bus_wr && bus_addr == 2'd3) begin m_lvl = bus_wdata[0]; m_dir = bus_wdata[1]; end
   endtask

   // the DMA write is taken when the clear came from it: empty was 1 before the edge
   bit dma_ok;
   function automatic bit m_empty_prev_ok(input bit clr);
      return dma_ok && clr;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc_n);
      end
   endtask

   task automatic compare_all();
      int exp_txd;
      if (m_en) exp_txd = m_busy ? int'(m_frame[m_cnt / BIT_T]) : 1;
      else      exp_txd = m_dir ? int'(m_lvl) : 1;
      chk(m_en ? tx_tag : "R8", "txd", int'(txd), exp_txd);
      chk("R4", "txe_irq", int'(irq), int'(m_en && m_empty));
      case (bus_addr)
         2'd0: chk("R9", "holding", int'(bus_rdata), int'(m_hold));
         2'd1: chk(st_tag, "status", int'(bus_rdata),
                   int'({m_empty, 4'b0, m_done, 1'b0, m_abit}));
         2'd2: chk("R7", "control", int'(bus_rdata), int'(m_en));
         default: chk("R8", "port", int'(bus_rdata), int'({m_dir, m_lvl}));
      endcase
   endtask

   task automatic step();
      @(posedge clk);
      dma_ok = dma_wr && m_empty;
      if (rst_n) model_edge(); else model_reset();
      @(negedge clk);
      cyc_n++;
      if (rst_n) compare_all();
      bus_wr = 0; dma_wr = 0; bus_addr = 2'd1;
      tick = ((cyc_n % tick_div) == 0);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      step();
   endtask

   task automatic wait_irq();
      int k = 0;
      while (!(m_en && m_empty) && k < 5000) begin step(); k++; end
      if (k >= 5000) chk("R4", "wait for request", 0, 1);
   endtask

   task automatic wait_done();
      int k = 0;
      while (!(m_done && !m_busy) && k < 5000) begin step(); k++; end
      if (k >= 5000) chk("R6", "wait for done", 0, 1);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      dma_ok = 0;
      repeat (3) step();
      rst_n = 1;
      // R1: reset state on pin and status
      repeat (3) step();

      // R2, R3: polled transmission with address bit 1 then 0
      tx_tag = "R2"; st_tag = "R3"; tick_div = 2;
      wr(2'd2, 8'h01);
      wr(2'd0, 8'hA5);
      wr(2'd1, 8'h01);
      wait_irq();
      wr(2'd0, 8'h3C);
      wr(2'd1, 8'h00);
      // R10: status write with bit 7 = 1 and bit 2 = 1 changes no flag
      st_tag = "R10";
      wr(2'd1, 8'h84);
      repeat (4) step();
      wr(2'd1, 8'h80);
      st_tag = "R3";
      wait_done();
      st_tag = "R10";
      wr(2'd0, 8'h55);
      wr(2'd1, 8'h80);
      repeat (20) step();

      // R5, R9: DMA-serviced frames; a second pulse while empty is 0 is ignored
      tx_tag = "R5"; st_tag = "R3"; tick_div = 1;
      for (int f = 0; f < 3; f++) begin
         wait_irq();
         dma_wr = 1; dma_wdata = 8'h96 + 8'(f);
         step();
         dma_wr = 1; dma_wdata = 8'hFF;
         step();
         bus_addr = 2'd0;
         step();
      end
      wait_done();

      // R6: empty cleared on the very edge the stop bit ends
      tx_tag = "R6"; st_tag = "R6";
      wr(2'd0, 8'h11);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h22);
      begin
         int k = 0;
         while (!(m_busy && m_cnt == LAST_T) && k < 5000) begin step(); k++; end
      end
      wr(2'd1, 8'h01);
      repeat (5) step();
      wait_done();
      repeat (3) step();

      // R7, R8: abort mid-frame and hold a break
      tx_tag = "R7"; st_tag = "R7";
      wr(2'd0, 8'h0F);
      wr(2'd1, 8'h00);
      repeat (40) step();
      wr(2'd3, 8'h02);
      repeat (3) step();
      wr(2'd2, 8'h00);
      repeat (20) step();
      bus_addr = 2'd3; step();
      wr(2'd3, 8'h03);
      repeat (5) step();
      wr(2'd3, 8'h00);
      repeat (5) step();
      wr(2'd2, 8'h01);
      tx_tag = "R2";
      repeat (10) step();

      finished = 1;
      summary();
      $finish;
   end
endmodule